// File: doc/BRIEF.md
# Pipelined Output and Sleep Control

This block owns the data-output side and the low-power state of a pipelined synchronous static RAM. Each clock edge it takes the command that the decoder has just qualified: whether the device is selected, and whether the selected cycle is a read. That command passes through an enable stage and then an enable-delay stage. A read therefore drives the data pins one cycle after it is registered, from an output data register. A deselect stops the drivers only once it has passed through both stages, so a read already in flight is still presented (double-cycle deselect).

Two inputs are not tied to the clock. Output enable (active low) gates the drivers directly, with no register in the path. A sleep request is counted through a fixed chain of clocked stages. When the chain fills, the block enters the low-power state: it raises an "inputs ignored" flag, turns the drivers off and treats every command as a deselect. When sleep is released, the chain drains over the same number of edges before commands are sampled again. The array and the command decoder are not part of this block. The read data that the array returns for the registered read is an input.

Top module: `sram_out_ctl`

## Requirements
- R1: While reset is asserted and right after it, `dq_oe_o` and `ign_o` are 0.
- R2: A read (`sel_i`=1, `rd_i`=1) registered at edge E, with `ign_o`=0 before E, drives the pins after edge E+1: `dq_oe_o`=1 and `dq_o` equals the `rdata_i` value presented between E and E+1. Back-to-back reads stream one word per cycle.
- R3: A deselect (`sel_i`=0) registered at edge E leaves the drivers on after E if a read was registered at E-1, and turns them off after E+1.
- R4: A write (`sel_i`=1, `rd_i`=0) never turns the drivers on, even with `oe_n_i`=0.
- R5: `oe_n_i`=1 forces `dq_oe_o` to 0 at once, with no clock edge. Lowering it again restores the drive of the read in flight.
- R6: If `sleep_i` is 1 at edge K and at every edge after it, `ign_o` is still 0 after edge K and is 1 after edge K+1.
- R7: While `ign_o`=1, `dq_oe_o` is 0, and a command presented at an edge with `ign_o`=1 has no effect. The pipeline is empty when `ign_o` falls.
- R8: If `sleep_i` is 0 at edge M and after, `ign_o` is still 1 after M and 0 after M+1. A read at M+1 is ignored, and a read at M+2 drives after M+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Decoded command selects the device this edge |
| rd_i | input | 1 | Selected command is a read (0 means write) |
| oe_n_i | input | 1 | Output enable, active low, not clocked |
| sleep_i | input | 1 | Low-power request, not clocked |
| rdata_i | input | DATA_W | Array data for the read registered at the previous edge |
| dq_o | output | DATA_W | Output data register |
| dq_oe_o | output | 1 | Data pin drive enable (0 means high impedance) |
| ign_o | output | 1 | Clocked inputs are being ignored (sleep window) |

## Verification
The hardest case to reach is a read still inside the two-stage pipeline at the moment sleep takes hold. That read must not reappear on the pins at wake-up. The command on the last edge before `ign_o` falls must also be dropped. The stimulus streams reads right up to the cycle in which `sleep_i` rises. It keeps issuing reads through the whole sleep period and the release, then checks the exact edges at which the flag changes. It also checks that the first driven word after wake-up belongs to the first read issued once `ign_o` is low.

// File: rtl/sram_oc_pkg.sv
package sram_oc_pkg;

    // command pipeline: enable stage, read flag, enable-delay (drive) stage
    typedef struct packed {
        logic en;
        logic rd;
        logic drv;
    } pipe_ctl_t;

    localparam int unsigned SLEEP_STAGES_DEF = 2;

endpackage

// File: rtl/sram_sleep_seq.sv
module sram_sleep_seq #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    output logic ign_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = sleep_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], sleep_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign ign_o = sh_q[STAGES-1];

endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe
    import sram_oc_pkg::*;
#(
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              rd_i,
    input  logic              ign_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              drv_o,
    output logic [DATA_W-1:0] data_o
);

    pipe_ctl_t         ctl_d, ctl_q;
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        ctl_d     = ctl_q;
        data_d    = data_q;
        // enable stage: an ignored command is a deselect
        ctl_d.en  = sel_i & ~ign_i;
        ctl_d.rd  = sel_i & rd_i & ~ign_i;
        // enable-delay stage: drive only for a read that was enabled
        ctl_d.drv = ctl_q.en & ctl_q.rd & ~ign_i;
        if (ctl_d.drv) data_d = rdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            data_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            data_q <= data_d;
        end
    end

    assign drv_o  = ctl_q.drv;
    assign data_o = data_q;

endmodule

// File: rtl/sram_out_ctl.sv
module sram_out_ctl
    import sram_oc_pkg::*;
#(
    parameter int unsigned DATA_W       = 36,
    parameter int unsigned SLEEP_STAGES = SLEEP_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              rd_i,
    input  logic              oe_n_i,
    input  logic              sleep_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              ign_o
);

    logic ign;
    logic drv;

    sram_sleep_seq #(
        .STAGES (SLEEP_STAGES)
    ) u_sleep (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .ign_o   (ign)
    );

    sram_out_pipe #(
        .DATA_W (DATA_W)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel_i),
        .rd_i    (rd_i),
        .ign_i   (ign),
        .rdata_i (rdata_i),
        .drv_o   (drv),
        .data_o  (dq_o)
    );

    // output enable acts without a clock; sleep state blocks the drivers
    assign dq_oe_o = drv & ~oe_n_i & ~ign;
    assign ign_o   = ign;

endmodule

// File: rtl/sram_out_ctl_chk.sv
module sram_out_ctl_chk #(
    parameter int unsigned DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic              rd_i,
    input logic              oe_n_i,
    input logic              sleep_i,
    input logic [DATA_W-1:0] rdata_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe_o,
    input logic              ign_o
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!dq_oe_o && !ign_o));

    a_r2_read_data: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && rd_i && !ign_o) ##1 !ign_o |=> (dq_o == $past(rdata_i)));

    a_r3_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> ##1 !dq_oe_o);

    a_r4_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !rd_i) |=> ##1 !dq_oe_o);

    a_r5_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !dq_oe_o);

    a_r6_entry_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ign_o) |-> ($past(sleep_i) && $past(sleep_i, 2)));

    a_r7_sleep_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        ign_o |-> !dq_oe_o);

    a_r8_exit_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ign_o) |-> (!$past(sleep_i) && !$past(sleep_i, 2) && !dq_oe_o));

endmodule

bind sram_out_ctl sram_out_ctl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_out_ctl_tb.sv
`timescale 1ns/1ps
module sram_out_ctl_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_i = 1'b0, rd_i = 1'b0, oe_n_i = 1'b0, sleep_i = 1'b0;
    logic [W-1:0] rdata_i = '0;
    logic [W-1:0] dq_o;
    logic         dq_oe_o, ign_o;

    sram_out_ctl #(.DATA_W(W), .SLEEP_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rd_i(rd_i), .oe_n_i(oe_n_i),
        .sleep_i(sleep_i), .rdata_i(rdata_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
        .ign_o(ign_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        int           stamp;
        bit           drv;
        logic [W-1:0] data;
        string        req;
    } exp_t;

    exp_t         sb[$];
    int           n_cmp = 0, n_bad = 0, edge_n = 0;
    bit           sb_on = 1'b0;
    bit           done = 1'b0;
    logic [W-1:0] pend_data = '0;

    always @(posedge clk) edge_n++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // drive one command for the next edge; rdata_i carries the data of the
    // read issued by the previous call
    task automatic step(input bit sel, input bit rd, input logic [W-1:0] d, input string req);
        @(negedge clk);
        sel_i     = sel;
        rd_i      = rd;
        rdata_i   = pend_data;
        pend_data = d;
        if (sb_on) sb.push_back('{edge_n + 2, sel && rd, d, req});
    endtask

    // monitor: compares scoreboard entries at the negedge after their edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].stamp <= edge_n) begin
            exp_t e;
            e = sb.pop_front();
            if (e.stamp == edge_n) begin
                check(dq_oe_o == e.drv, e.req, "dq_oe_o", W'(dq_oe_o), W'(e.drv));
                if (e.drv) check(dq_o == e.data, e.req, "dq_o", dq_o, e.data);
            end
        end
    end

    task automatic drain();
        sb_on = 1'b0;
        repeat (3) step(1'b0, 1'b0, '0, "");
        wait (sb.size() == 0);
    endtask

    initial begin
        #1;
        check(dq_oe_o == 1'b0, "R1", "dq_oe_o in reset", W'(dq_oe_o), '0);
        check(ign_o == 1'b0, "R1", "ign_o in reset", W'(ign_o), '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dq_oe_o == 1'b0, "R1", "dq_oe_o after reset", W'(dq_oe_o), '0);
        check(ign_o == 1'b0, "R1", "ign_o after reset", W'(ign_o), '0);

        // R2: back-to-back reads, gaps, repeated word
        sb_on = 1'b1;
        step(1, 1, 16'h1111, "R2");
        step(1, 1, 16'h2222, "R2");
        step(1, 1, 16'hA5A5, "R2");
        step(1, 1, 16'h5A5A, "R2");
        step(0, 0, 16'h0000, "R3");
        step(1, 1, 16'hBEEF, "R2");
        step(1, 1, 16'hBEEF, "R2");
        // R3: deselect after a read; the read still drives, then off
        step(0, 0, 16'h0000, "R3");
        step(0, 0, 16'h0000, "R3");
        // R4: writes never drive, mixed with reads
        step(1, 0, 16'hDEAD, "R4");
        step(1, 1, 16'h0F0F, "R2");
        step(1, 0, 16'hFFFF, "R4");
        step(1, 0, 16'h1234, "R4");
        step(1, 1, 16'h8001, "R2");
        step(0, 0, 16'h0000, "R3");
        drain();

        // R5: output enable acts immediately
        step(1, 1, 16'h7777, "");
        step(1, 1, 16'h6666, "");
        step(0, 0, 16'h0000, "");
        check(dq_oe_o == 1'b1, "R5", "drive before oe_n", W'(dq_oe_o), 1);
        #0.5 oe_n_i = 1'b1;
        #0.5 check(dq_oe_o == 1'b0, "R5", "oe_n high", W'(dq_oe_o), 0);
        oe_n_i = 1'b0;
        #0.5 check(dq_oe_o == 1'b1, "R5", "oe_n low again", W'(dq_oe_o), 1);
        check(dq_o == 16'h7777, "R5", "dq_o kept", dq_o, 16'h7777);
        drain();

        // R6/R7/R8: sleep entry with reads in flight, sleep, exit
        step(1, 1, 16'hC001, "");
        step(1, 1, 16'hC002, "");
        sleep_i = 1'b1;                               // set before edge K
        step(1, 1, 16'hC003, "");                     // now after K
        check(ign_o == 1'b0, "R6", "ign_o after K", W'(ign_o), 0);
        check(dq_oe_o == 1'b1 && dq_o == 16'hC001, "R2", "read before sleep",
              dq_o, 16'hC001);
        step(1, 1, 16'hC004, "");                     // after K+1
        check(ign_o == 1'b1, "R6", "ign_o after K+1", W'(ign_o), 1);
        check(dq_oe_o == 1'b0, "R7", "dq_oe_o entering sleep", W'(dq_oe_o), 0);
        for (int i = 0; i < 4; i++) begin
            step(1, 1, W'(16'hD000 + i), "");
            check(ign_o == 1'b1, "R7", "ign_o held", W'(ign_o), 1);
            check(dq_oe_o == 1'b0, "R7", "dq_oe_o asleep", W'(dq_oe_o), 0);
        end
        step(1, 1, 16'hE001, "");
        sleep_i = 1'b0;                               // cleared before edge M
        step(1, 1, 16'hE002, "");                     // after M; read at M+1
        check(ign_o == 1'b1, "R8", "ign_o after M", W'(ign_o), 1);
        check(dq_oe_o == 1'b0, "R7", "dq_oe_o after M", W'(dq_oe_o), 0);
        step(1, 1, 16'hE003, "");                     // after M+1; read at M+2
        check(ign_o == 1'b0, "R8", "ign_o after M+1", W'(ign_o), 0);
        check(dq_oe_o == 1'b0, "R7", "pipeline empty at wake", W'(dq_oe_o), 0);
        step(0, 0, 16'h0000, "");                     // after M+2
        check(dq_oe_o == 1'b0, "R8", "read at M+1 ignored", W'(dq_oe_o), 0);
        step(0, 0, 16'h0000, "");                     // after M+3
        check(dq_oe_o == 1'b1, "R8", "first read after wake drives", W'(dq_oe_o), 1);
        check(dq_o == 16'hE003, "R8", "first word after wake", dq_o, 16'hE003);
        step(0, 0, 16'h0000, "");
        check(dq_oe_o == 1'b0, "R3", "off after deselect", W'(dq_oe_o), 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R1-all watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule